// File: doc/BRIEF.md
# Virtualized Guest Timer Compare Unit

This block produces the timer-pending bit seen by a guest running under a hypervisor. It holds a 64-bit guest compare value and a 64-bit time offset. Guest time is the machine time input plus the offset, with wraparound at 64 bits. The guest timer tick is asserted while guest time, as an unsigned number, is greater than or equal to the compare value. The visible pending bit is that tick ORed with a pending bit injected by software. Because the pending bit is read-only, the only way to lower it is to move the compare value or the offset.

Both registers sit behind a single-cycle CSR access port. In the default 32-bit configuration each register is split into a low half and a high half, and each half is written separately. An access made from guest mode to the compare register passes through two counter-enable bits. A clear machine bit gives an illegal-instruction fault. A set machine bit with a clear hypervisor bit gives a virtual-instruction fault. The offset register is for the hypervisor only. The machine time counter, interrupt enable and delegation, and trap entry are all outside this block.

Top module: `vtimer_cmp_unit`

## Requirements
- R1: After reset the compare register reads all ones, the offset register reads zero, and with `inj_pend_i` low and `mtime_i` below all ones `pend_o` is 0.
- R2: Guest time is (`mtime_i` + offset) mod 2^64. The tick is 1 exactly when guest time >= compare, unsigned.
- R3: `tick_o` is registered. A write to compare or offset, or a change of `mtime_i`, reaches `pend_o` at the second clock edge after the write is presented (the first edge for `mtime_i`). Until then `pend_o` keeps its old value.
- R4: `pend_o` = `inj_pend_i` OR tick. Injection has combinational effect.
- R5: `pend_o` does not depend on `guest_mode_i`.
- R6: With XLEN=32, compare low/high are at 0x208/0x209 and offset low/high are at 0x605/0x615. Each half is written independently. A read returns that half combinationally, and a write takes effect at the next edge.
- R7: A guest-mode access to the compare register with `m_tm_i`=0 gives `csr_fault_o`=2'b01 (illegal), whatever `h_tm_i` is.
- R8: A guest-mode access to the compare register with `m_tm_i`=1 and `h_tm_i`=0 gives `csr_fault_o`=2'b10 (virtual).
- R9: A guest-mode access to the offset register gives 2'b10. A non-guest access to any mapped register gives 2'b00, whatever the TM bits are. A guest access to the compare register with both TM bits set also gives 2'b00.
- R10: An access to an unmapped address gives 2'b01.
- R11: A faulted access changes no register and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| mtime_i | input | 64 | machine time |
| csr_req_i | input | 1 | CSR access valid |
| csr_we_i | input | 1 | access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | write data |
| guest_mode_i | input | 1 | access issued from guest mode |
| m_tm_i | input | 1 | machine-level time enable bit |
| h_tm_i | input | 1 | hypervisor-level time enable bit |
| inj_pend_i | input | 1 | software-injected pending bit |
| csr_rdata_o | output | XLEN | read data, 0 on fault or no access |
| csr_fault_o | output | 2 | 00 none, 01 illegal, 10 virtual |
| tick_o | output | 1 | registered guest timer tick |
| pend_o | output | 1 | visible guest timer-pending bit |

## Verification
The assertions assume three things about the inputs. The CSR request, address and TM bits are stable for the whole cycle of an access. `mtime_i` changes only between edges. The checks that relate inputs to the tick look only one edge ahead. The stimulus drives every input one time unit after a rising edge, holds `mtime_i` constant across each write and its settling cycle, and issues at most one access per cycle. Deliberate wraparound cases place `mtime_i` close to 2^64.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ILLEGAL = 2'b01,
    FLT_VIRTUAL = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_OFF_LO,
    SEL_OFF_HI
  } sel_e;
endpackage

// File: rtl/vtc_csr_decode.sv
module vtc_csr_decode
  import vtc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter logic [11:0] CMP_LO_ADDR = 12'h208,
  parameter logic [11:0] CMP_HI_ADDR = 12'h209,
  parameter logic [11:0] OFF_LO_ADDR = 12'h605,
  parameter logic [11:0] OFF_HI_ADDR = 12'h615
) (
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic        guest_i,
  input  logic        m_tm_i,
  input  logic        h_tm_i,
  output sel_e        sel_o,
  output fault_e      fault_o,
  output logic        wr_en_o,
  output logic        rd_en_o
);
  localparam bit HAS_HI = (XLEN == 32);

  sel_e   sel;
  fault_e fault;
  logic   is_off;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == CMP_LO_ADDR)                sel = SEL_CMP_LO;
    else if (HAS_HI && addr_i == CMP_HI_ADDR) sel = SEL_CMP_HI;
    else if (addr_i == OFF_LO_ADDR)           sel = SEL_OFF_LO;
    else if (HAS_HI && addr_i == OFF_HI_ADDR) sel = SEL_OFF_HI;
  end

  assign is_off = (sel == SEL_OFF_LO) || (sel == SEL_OFF_HI);

  // two-level enable: machine bit first, then hypervisor bit
  always_comb begin
    fault = FLT_NONE;
    if (req_i) begin
      if (sel == SEL_NONE)  fault = FLT_ILLEGAL;
      else if (guest_i) begin
        if (is_off)         fault = FLT_VIRTUAL;
        else if (!m_tm_i)   fault = FLT_ILLEGAL;
        else if (!h_tm_i)   fault = FLT_VIRTUAL;
      end
    end
  end

  assign sel_o   = sel;
  assign fault_o = fault;
  assign rd_en_o = req_i && (fault == FLT_NONE);
  assign wr_en_o = rd_en_o && we_i;
endmodule

// File: rtl/vtc_regfile.sv
module vtc_regfile
  import vtc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  sel_e            sel_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [63:0]     cmp_o,
  output logic [63:0]     off_o
);
  logic [63:0]     cmp_q, off_q;
  logic [XLEN-1:0] rmux;

  if (XLEN == 32) begin : g_split
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q <= '1;
        off_q <= '0;
      end else if (wr_en_i) begin
        case (sel_i)
          SEL_CMP_LO: cmp_q[31:0]  <= wdata_i;
          SEL_CMP_HI: cmp_q[63:32] <= wdata_i;
          SEL_OFF_LO: off_q[31:0]  <= wdata_i;
          SEL_OFF_HI: off_q[63:32] <= wdata_i;
          default: ;
        endcase
      end
    end
    always_comb begin
      case (sel_i)
        SEL_CMP_LO: rmux = cmp_q[31:0];
        SEL_CMP_HI: rmux = cmp_q[63:32];
        SEL_OFF_LO: rmux = off_q[31:0];
        SEL_OFF_HI: rmux = off_q[63:32];
        default:    rmux = '0;
      endcase
    end
  end else begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q <= '1;
        off_q <= '0;
      end else if (wr_en_i) begin
        case (sel_i)
          SEL_CMP_LO: cmp_q <= wdata_i;
          SEL_OFF_LO: off_q <= wdata_i;
          default: ;
        endcase
      end
    end
    always_comb begin
      case (sel_i)
        SEL_CMP_LO: rmux = cmp_q;
        SEL_OFF_LO: rmux = off_q;
        default:    rmux = '0;
      endcase
    end
  end

  assign rdata_o = rd_en_i ? rmux : '0;
  assign cmp_o   = cmp_q;
  assign off_o   = off_q;
endmodule

// File: rtl/vtc_compare.sv
module vtc_compare (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] mtime_i,
  input  logic [63:0] cmp_i,
  input  logic [63:0] off_i,
  output logic        tick_o
);
  logic [63:0] guest_time;
  logic        tick_q;

  assign guest_time = mtime_i + off_i; // wraps mod 2^64

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= (guest_time >= cmp_i);
  end

  assign tick_o = tick_q;

  // R2
  zero_off_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i == 64'd0 && mtime_i >= cmp_i) |=> tick_o);

  // R2
  zero_off_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i == 64'd0 && mtime_i < cmp_i) |=> !tick_o);
endmodule

// File: rtl/vtimer_cmp_unit.sv
module vtimer_cmp_unit
  import vtc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter logic [11:0] CMP_LO_ADDR = 12'h208,
  parameter logic [11:0] CMP_HI_ADDR = 12'h209,
  parameter logic [11:0] OFF_LO_ADDR = 12'h605,
  parameter logic [11:0] OFF_HI_ADDR = 12'h615
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [63:0]     mtime_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            guest_mode_i,
  input  logic            m_tm_i,
  input  logic            h_tm_i,
  input  logic            inj_pend_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic [1:0]      csr_fault_o,
  output logic            tick_o,
  output logic            pend_o
);
  sel_e        sel;
  fault_e      fault;
  logic        wr_en, rd_en;
  logic [63:0] cmp_w, off_w;

  vtc_csr_decode #(
    .XLEN(XLEN), .CMP_LO_ADDR(CMP_LO_ADDR), .CMP_HI_ADDR(CMP_HI_ADDR),
    .OFF_LO_ADDR(OFF_LO_ADDR), .OFF_HI_ADDR(OFF_HI_ADDR)
  ) u_dec (
    .req_i(csr_req_i), .we_i(csr_we_i), .addr_i(csr_addr_i),
    .guest_i(guest_mode_i), .m_tm_i(m_tm_i), .h_tm_i(h_tm_i),
    .sel_o(sel), .fault_o(fault), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  vtc_regfile #(.XLEN(XLEN)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(csr_wdata_i), .rdata_o(csr_rdata_o),
    .cmp_o(cmp_w), .off_o(off_w)
  );

  vtc_compare u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .mtime_i(mtime_i),
    .cmp_i(cmp_w), .off_i(off_w), .tick_o(tick_o)
  );

  assign csr_fault_o = fault;
  assign pend_o      = tick_o | inj_pend_i;

  // R11
  fault_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_we_i && csr_fault_o != FLT_NONE) |=> ($stable(cmp_w) && $stable(off_w)));

  // R4
  inj_forces_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_pend_i |-> pend_o);

  // R7
  mtm_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && guest_mode_i && !m_tm_i && csr_addr_i == CMP_LO_ADDR) |-> csr_fault_o == FLT_ILLEGAL);

  // R9
  host_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && !guest_mode_i && (csr_addr_i == CMP_LO_ADDR || csr_addr_i == OFF_LO_ADDR))
      |-> csr_fault_o == FLT_NONE);
endmodule

// File: tb/vtimer_cmp_unit_bench.sv
module vtimer_cmp_unit_bench;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [63:0]     mtime_i = '0;
  logic            csr_req_i = 1'b0, csr_we_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic            guest_mode_i = 1'b0, m_tm_i = 1'b1, h_tm_i = 1'b1, inj_pend_i = 1'b0;
  logic [XLEN-1:0] csr_rdata_o;
  logic [1:0]      csr_fault_o;
  logic            tick_o, pend_o;

  vtimer_cmp_unit #(.XLEN(XLEN)) u_vtimer_cmp_unit (.*);

  always #5ns clk_i = ~clk_i;

  typedef struct {
    int          kind; // 0 rdata, 1 fault, 2 pend
    string       req;
    logic [63:0] exp;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0, failures = 0;
  logic [63:0] m_cmp = '1, m_off = '0;
  bit          done = 1'b0;

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = 64'(csr_rdata_o);
        1:       act = 64'(csr_fault_o);
        default: act = 64'(pend_o);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic model_pend();
    return ((mtime_i + m_off) >= m_cmp) | inj_pend_i;
  endfunction

  task automatic csr(input bit g, input bit mt, input bit ht, input bit we,
                     input logic [11:0] a, input logic [31:0] wd,
                     input logic [1:0] efault, input logic [31:0] erd, input string r);
    @(posedge clk_i); #1;
    csr_req_i = 1'b1; csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd;
    guest_mode_i = g; m_tm_i = mt; h_tm_i = ht;
    sb_q.push_back('{1, r, 64'(efault)});
    if (!we) sb_q.push_back('{0, r, 64'(erd)});
    if (we && efault == 2'b00) begin
      case (a)
        12'h208: m_cmp[31:0]  = wd;
        12'h209: m_cmp[63:32] = wd;
        12'h605: m_off[31:0]  = wd;
        12'h615: m_off[63:32] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    csr_req_i = 1'b0; csr_we_i = 1'b0; guest_mode_i = 1'b0; m_tm_i = 1'b1; h_tm_i = 1'b1;
  endtask

  task automatic set_mtime(input logic [63:0] v);
    @(posedge clk_i); #1;
    csr_req_i = 1'b0; mtime_i = v;
  endtask

  task automatic chk_pend(input string r);
    idle();
    sb_q.push_back('{2, r, 64'(model_pend())});
  endtask

  task automatic chk_pend_val(input logic e, input string r);
    idle();
    sb_q.push_back('{2, r, 64'(e)});
  endtask

  task automatic hw(input logic [11:0] a, input logic [31:0] wd, input string r);
    csr(1'b0, 1'b1, 1'b1, 1'b1, a, wd, 2'b00, 32'h0, r);
  endtask

  task automatic hr(input logic [11:0] a, input logic [31:0] e, input string r);
    csr(1'b0, 1'b1, 1'b1, 1'b0, a, 32'h0, 2'b00, e, r);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk_pend("R1");
    hr(12'h208, 32'hFFFF_FFFF, "R1");
    hr(12'h209, 32'hFFFF_FFFF, "R1");
    hr(12'h605, 32'h0, "R1");
    hr(12'h615, 32'h0, "R1");
    // R6 half writes
    set_mtime(64'h10);
    hw(12'h209, 32'h0, "R6");
    hw(12'h208, 32'h20, "R6");
    hr(12'h208, 32'h20, "R6");
    hr(12'h209, 32'h0, "R6");
    idle(); chk_pend("R2 below");
    set_mtime(64'h20); chk_pend("R2 equal");
    set_mtime(64'h21); chk_pend("R2 above");
    // R2 wraparound of guest time
    set_mtime(64'hFFFF_FFFF_FFFF_FFF0);
    hw(12'h605, 32'h20, "R6");
    hw(12'h208, 32'h100, "R6");
    hr(12'h605, 32'h20, "R6");
    idle(); chk_pend("R2 wrap");
    hw(12'h208, 32'h10, "R2");
    idle(); chk_pend("R2 wrap equal");
    // R3 latency: old value holds one cycle after the write
    hw(12'h208, 32'h11, "R3");
    chk_pend_val(1'b1, "R3 old");
    chk_pend_val(1'b0, "R3 new");
    // R4 injection
    @(posedge clk_i); #1 inj_pend_i = 1'b1;
    sb_q.push_back('{2, "R4", 64'd1});
    @(posedge clk_i); #1 inj_pend_i = 1'b0;
    chk_pend("R4 off");
    // R5 guest mode does not gate pending
    hw(12'h208, 32'h0, "R5");
    idle();
    @(posedge clk_i); #1 guest_mode_i = 1'b1;
    sb_q.push_back('{2, "R5", 64'(model_pend())});
    @(posedge clk_i); #1 guest_mode_i = 1'b0;
    hw(12'h208, 32'h11, "R5");
    // R7 illegal, write blocked (R11)
    csr(1'b1, 1'b0, 1'b1, 1'b1, 12'h208, 32'h5, 2'b01, 32'h0, "R7");
    csr(1'b1, 1'b0, 1'b0, 1'b0, 12'h208, 32'h0, 2'b01, 32'h0, "R7 R11");
    hr(12'h208, 32'h11, "R11");
    // R8 virtual
    csr(1'b1, 1'b1, 1'b0, 1'b1, 12'h209, 32'h7, 2'b10, 32'h0, "R8");
    csr(1'b1, 1'b1, 1'b0, 1'b0, 12'h208, 32'h0, 2'b10, 32'h0, "R8 R11");
    hr(12'h209, 32'h0, "R11");
    // R9 permitted and offset protection
    csr(1'b1, 1'b1, 1'b1, 1'b0, 12'h208, 32'h0, 2'b00, 32'h11, "R9");
    csr(1'b1, 1'b1, 1'b1, 1'b1, 12'h208, 32'h30, 2'b00, 32'h0, "R9");
    hr(12'h208, 32'h30, "R9");
    csr(1'b1, 1'b1, 1'b1, 1'b0, 12'h605, 32'h0, 2'b10, 32'h0, "R9");
    csr(1'b1, 1'b1, 1'b1, 1'b1, 12'h615, 32'h9, 2'b10, 32'h0, "R9");
    csr(1'b0, 1'b0, 1'b0, 1'b0, 12'h208, 32'h0, 2'b00, 32'h30, "R9");
    hr(12'h615, 32'h0, "R11");
    // R10 unmapped
    csr(1'b0, 1'b1, 1'b1, 1'b0, 12'h300, 32'h0, 2'b01, 32'h0, "R10");
    idle(); chk_pend("R2 final");
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule